// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus of a small 8-bit processor whose low address byte and data share one byte-wide lane. The core places a request: memory or I/O space, read, write or opcode fetch, a 16-bit address and write data. The block turns that request into a machine cycle. In the first state the lane carries the low address, and an address strobe tells peripherals to latch it. In the following states the lane carries data, framed by active-low read or write strobes. The high address byte and the cycle status come out on their own pins and stay steady for the whole cycle.

A slow target can stretch the cycle by holding a ready input low. Another bus master can claim the bus with a hold request. The block finishes any transfer in flight, raises hold-acknowledge on the next rising edge and lets go of the bus half a clock later. It retakes the bus half a clock after the acknowledge drops. The bus drivers are also switched off during reset and while the core is halted. The address strobe is never switched off. Tristate is shown through two enables: `bus_oe` covers the high address, the strobes and the space pin, and `ad_oe` covers the shared lane.

The core keeps `req_valid` and its request fields steady until it sees `done`, and it drops `req_valid` on the clock edge that follows. Read data is valid on `rdata` while `done` is high.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst_n` is low, whether asserted from idle or in the middle of a cycle, `bus_oe`, `ad_oe`, `ale`, `hlda` and `done` are 0 and `rd_n` and `wr_n` are 1.
- R2: One clock after an idle controller with the bus enabled samples `req_valid` high, state T1 begins. For exactly that one clock `ale` is 1, `ad_oe` is 1, `ad_out` equals the address bits [7:0] and `addr_hi` equals the address bits [15:8].
- R3: Inside a machine cycle {`s1`,`s0`} is 2'b01 for a write, 2'b11 for a memory opcode fetch and 2'b10 for any other read. `iom` is 1 for I/O space. These outputs hold steady from T1 through T3. Outside a cycle {`s1`,`s0`} is 2'b00.
- R4: In a read, `rd_n` is 0 from T2 through T3, `wr_n` stays 1 and `ad_oe` is 0. While `done` is 1, `rdata` shows the value on `ad_in`.
- R5: In a write, `wr_n` is 0 from T2 through T3, `rd_n` stays 1, and `ad_oe` is 1 with `ad_out` equal to the write data up to and including T3.
- R6: `ready` is sampled at the end of T2 and at the end of each wait state. Each low sample adds one wait clock, so a cycle lasts 3 + N clocks for N low samples.
- R7: `done` is 1 for exactly the last clock (T3) of every cycle.
- R8: A `hold` sampled while idle or at the end of T3 raises `hlda` on that edge. A cycle already in progress completes first. `bus_oe` and `ad_oe` fall half a clock after `hlda` rises, and no new cycle starts while `hlda` is 1.
- R9: `hlda` falls on the first edge that samples `hold` low. `bus_oe` returns half a clock later, and a pending request starts T1 on the next edge.
- R10: While idle with `halt_i` 1 and no request, `bus_oe` and `ad_oe` are 0 and {`s1`,`s0`} is 2'b00. A request raised during halt re-enables the bus and runs a normal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request, held until done |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_io | input | 1 | 1 for I/O space, 0 for memory |
| req_fetch | input | 1 | Read is an opcode fetch |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| halt_i | input | 1 | Core is halted |
| done | output | 1 | Last clock of the cycle |
| rdata | output | 8 | Read data, valid with done |
| ready | input | 1 | Target ready, low inserts waits |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| iom | output | 1 | 1 for I/O space |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| addr_hi | output | 8 | Upper address byte |
| bus_oe | output | 1 | Enable for addr_hi, rd_n, wr_n, iom |
| ad_out | output | 8 | Shared lane drive value |
| ad_oe | output | 1 | Shared lane drive enable |
| ad_in | input | 8 | Shared lane received value |

## Verification
The bench targets cycles stretched by one to three wait states. A controller that samples ready in the wrong state would show `done` one clock early or late. The bench raises a hold request in the middle of a transfer: a design that gave the bus up at once would raise `hlda` during T3, with the strobes still active. The bench measures both hold hand-offs at the quarter-clock point, which catches a release made on the same edge as `hlda` and a retake that waits a full clock. It also covers a reset in the middle of a cycle and halt followed by a request: a wrong design leaves the lane driven or never re-enables the bus, so the request hangs.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_wr,
  input  logic          req_io,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          halt_i,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          iom,
  output logic          s1,
  output logic          s0,
  output logic [AW-DW-1:0] addr_hi,
  output logic          bus_oe,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HELD
  } st_t;

  st_t           st;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          wr_q, io_q, bus_en;
  logic [1:0]    s_q;
  logic          strobe, in_cyc, quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      a_q  <= '0;
      d_q  <= '0;
      wr_q <= 1'b0;
      io_q <= 1'b0;
      s_q  <= 2'b00;
    end else begin
      case (st)
        ST_IDLE: begin
          if (hold) st <= ST_HELD;
          else if (req_valid && bus_en) begin
            st   <= ST_T1;
            a_q  <= req_addr;
            d_q  <= req_wdata;
            wr_q <= req_wr;
            io_q <= req_io;
            s_q  <= req_wr ? 2'b01 : ((req_fetch && !req_io) ? 2'b11 : 2'b10);
          end
        end
        ST_T1:   st <= ST_T2;
        ST_T2:   st <= ready ? ST_T3 : ST_TW;
        ST_TW:   st <= ready ? ST_T3 : ST_TW;
        ST_T3:   st <= hold ? ST_HELD : ST_IDLE;
        ST_HELD: if (!hold) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign quiet = (st == ST_HELD) || (st == ST_IDLE && halt_i && !req_valid);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bus_en <= 1'b0;
    else        bus_en <= !quiet;
  end

  assign strobe   = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
  assign in_cyc   = strobe || (st == ST_T1);
  assign ale      = (st == ST_T1);
  assign hlda     = (st == ST_HELD);
  assign done     = (st == ST_T3);
  assign rd_n     = !(strobe && !wr_q);
  assign wr_n     = !(strobe && wr_q);
  assign {s1, s0} = in_cyc ? s_q : 2'b00;
  assign iom      = in_cyc && io_q;
  assign addr_hi  = a_q[AW-1:DW];
  assign bus_oe   = bus_en;
  assign ad_oe    = bus_en && (ale || (strobe && wr_q));
  assign ad_out   = ale ? a_q[DW-1:0] : d_q;
  assign rdata    = ad_in;

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic iom,
  input logic s1,
  input logic s0,
  input logic ad_oe,
  input logic bus_oe,
  input logic hlda,
  input logic hold,
  input logic done,
  input logic ready
);

  // R1
  always @(posedge clk)
    if (rst_n === 1'b0)
      reset_quiet_chk: assert (!bus_oe && !ad_oe && !ale && !hlda && rd_n && wr_n);

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3
  status_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> $stable({s1, s0, iom}));

  // R4
  read_lane_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && wr_n));

  // R5
  write_lane_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R6
  done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ready));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  held_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ale && rd_n && wr_n));

  // R8
  hlda_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold));

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (.*);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic       wr;
    logic       io;
    logic       fetch;
    logic [15:0] addr;
    logic [7:0] wdata;
    logic [2:0] nwait;
    logic [7:0] rin;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b1, 16'h12A5, 8'h00, 3'd0, 8'h3C},
    '{1'b0, 1'b1, 1'b0, 16'h0047, 8'h00, 3'd0, 8'hC9},
    '{1'b1, 1'b0, 1'b0, 16'hBEEF, 8'h5A, 3'd0, 8'h00},
    '{1'b1, 1'b1, 1'b0, 16'h00F0, 8'hA7, 3'd1, 8'h00},
    '{1'b0, 1'b0, 1'b0, 16'h8001, 8'h00, 3'd2, 8'h81},
    '{1'b1, 1'b0, 1'b0, 16'h7FFE, 8'h0F, 3'd3, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, req_io = 1'b0, req_fetch = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic halt_i = 1'b0, ready = 1'b1, hold = 1'b0;
  logic done, hlda, ale, rd_n, wr_n, iom, s1, s0, bus_oe, ad_oe;
  logic [7:0] rdata, addr_hi, ad_out;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_io(req_io), .req_fetch(req_fetch), .req_addr(req_addr),
    .req_wdata(req_wdata), .halt_i(halt_i), .done(done), .rdata(rdata),
    .ready(ready), .hold(hold), .hlda(hlda), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .iom(iom), .s1(s1), .s0(s0), .addr_hi(addr_hi),
    .bus_oe(bus_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic bus_cycle(input vec_t v, input logic hold_mid);
    logic [1:0] es;
    es = v.wr ? 2'b01 : ((v.fetch && !v.io) ? 2'b11 : 2'b10);
    @(posedge clk); #1;
    req_valid = 1'b1; req_wr = v.wr; req_io = v.io; req_fetch = v.fetch;
    req_addr = v.addr; req_wdata = v.wdata; ad_in = v.rin;
    ready = (v.nwait == 0);
    @(posedge clk); #8;
    chk("R2 ale in T1", {31'd0, ale}, 1);
    chk("R2 lane enable in T1", {31'd0, ad_oe}, 1);
    chk("R2 low address", {24'd0, ad_out}, {24'd0, v.addr[7:0]});
    chk("R2 high address", {24'd0, addr_hi}, {24'd0, v.addr[15:8]});
    chk("R3 status", {30'd0, s1, s0}, {30'd0, es});
    chk("R3 space", {31'd0, iom}, {31'd0, v.io});
    @(posedge clk); #8;
    chk("R2 ale low in T2", {31'd0, ale}, 0);
    chk("R4 rd_n in T2", {31'd0, rd_n}, {31'd0, v.wr});
    chk("R5 wr_n in T2", {31'd0, wr_n}, {31'd0, !v.wr});
    chk("R4 R5 lane enable in T2", {31'd0, ad_oe}, {31'd0, v.wr});
    chk("R3 status held", {30'd0, s1, s0}, {30'd0, es});
    if (hold_mid) hold = 1'b1;
    for (int i = 0; i < int'(v.nwait); i++) begin
      @(posedge clk); #8;
      chk("R6 no done in wait", {31'd0, done}, 0);
      chk("R6 strobe held in wait", {31'd0, rd_n & wr_n}, 0);
      if (i == int'(v.nwait) - 1) ready = 1'b1;
    end
    @(posedge clk); #8;
    chk("R7 done in T3", {31'd0, done}, 1);
    chk("R3 status held in T3", {31'd0, iom}, {31'd0, v.io});
    if (hold_mid) chk("R8 no hlda before transfer ends", {31'd0, hlda}, 0);
    if (v.wr) begin
      chk("R5 data held in T3", {24'd0, ad_out}, {24'd0, v.wdata});
      chk("R5 lane driven in T3", {31'd0, ad_oe}, 1);
    end else
      chk("R4 read data", {24'd0, rdata}, {24'd0, v.rin});
    @(posedge clk); #1;
    req_valid = 1'b0;
    #7;
    chk("R7 done single", {31'd0, done}, 0);
    chk("R3 idle status", {30'd0, s1, s0}, 0);
    chk("R4 R5 strobes idle", {30'd0, rd_n, wr_n}, 3);
    if (hold_mid) begin
      chk("R8 hlda after transfer", {31'd0, hlda}, 1);
      chk("R8 bus released", {31'd0, bus_oe}, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    vec_t rv;
    repeat (3) @(posedge clk);
    #8;
    chk("R1 bus_oe reset", {31'd0, bus_oe}, 0);
    chk("R1 ad_oe reset", {31'd0, ad_oe}, 0);
    chk("R1 strobes reset", {28'd0, ale, hlda, rd_n, wr_n}, 4'b0011);
    chk("R1 done reset", {31'd0, done}, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    foreach (VECS[k]) bus_cycle(VECS[k], 1'b0);

    rv = '{1'b0, 1'b0, 1'b0, 16'h4321, 8'h00, 3'd1, 8'h66};
    bus_cycle(rv, 1'b1);
    @(posedge clk); #1; hold = 1'b0;
    @(posedge clk); #3;
    chk("R9 hlda drops", {31'd0, hlda}, 0);
    chk("R9 bus not yet back", {31'd0, bus_oe}, 0);
    #5;
    chk("R9 bus back half clock later", {31'd0, bus_oe}, 1);

    @(posedge clk); #1; hold = 1'b1;
    @(posedge clk); #3;
    chk("R8 hlda raised", {31'd0, hlda}, 1);
    chk("R8 bus kept first half", {31'd0, bus_oe}, 1);
    #5;
    chk("R8 bus released", {31'd0, bus_oe}, 0);
    chk("R8 lane released", {31'd0, ad_oe}, 0);
    req_valid = 1'b1; req_wr = 1'b0; req_io = 1'b1; req_fetch = 1'b0;
    req_addr = 16'h0099; ad_in = 8'hD2; ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #8;
      chk("R8 no cycle while held", {31'd0, ale}, 0);
    end
    @(posedge clk); #1; hold = 1'b0;
    @(posedge clk); #8;
    chk("R9 bus retaken", {31'd0, bus_oe}, 1);
    @(posedge clk); #8;
    chk("R9 pending request starts", {31'd0, ale}, 1);
    chk("R9 pending address", {24'd0, ad_out}, 32'h99);
    @(posedge clk); @(posedge clk); #8;
    chk("R9 pending request done", {31'd0, done}, 1);
    chk("R9 pending read data", {24'd0, rdata}, 32'hD2);
    @(posedge clk); #1; req_valid = 1'b0;

    @(posedge clk); #1; halt_i = 1'b1;
    @(posedge clk); #8;
    chk("R10 halt bus off", {31'd0, bus_oe}, 0);
    chk("R10 halt lane off", {31'd0, ad_oe}, 0);
    chk("R10 halt status", {30'd0, s1, s0}, 0);
    rv = '{1'b1, 1'b0, 1'b0, 16'hC0DE, 8'h99, 3'd0, 8'h00};
    bus_cycle(rv, 1'b0);
    @(posedge clk); #8;
    chk("R10 halt resumes", {31'd0, bus_oe}, 0);
    @(posedge clk); #1; halt_i = 1'b0;

    @(posedge clk); #1;
    req_valid = 1'b1; req_wr = 1'b1; req_io = 1'b0; req_addr = 16'h2222;
    req_wdata = 8'h44; ready = 1'b1;
    @(posedge clk); @(posedge clk); #8;
    chk("R5 write strobe before reset", {31'd0, wr_n}, 0);
    rst_n = 1'b0; req_valid = 1'b0;
    #1;
    chk("R1 mid-cycle reset lane", {31'd0, ad_oe}, 0);
    chk("R1 mid-cycle reset bus", {31'd0, bus_oe}, 0);
    chk("R1 mid-cycle reset strobes", {30'd0, rd_n, wr_n}, 3);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    summary();
  end
endmodule